// File: doc/BRIEF.md
# Single-Shot Checksum Readout Controller

This controller sits in the command path of a secure serial memory. Once a host has authenticated and then issued a write, the controller arms a virtual eight-byte checksum register. It places that register at a fixed read address. A read command that starts at that address while the register is armed returns the checksum bytes, one per transferred byte, in place of stored memory data. The controller also owns the read/write address counter and the select line of the read-data multiplexer.

The checksum is normally consumed by its first readout. Ending the readout early still uses it up. A read that starts anywhere else also disarms it. Only a fresh authentication followed by a write can arm it again. If the host keeps strobing bytes past the eighth checksum byte, the data path falls back to ordinary memory at the address that follows the checksum window. An active-low configuration bit selects an unlimited mode in which readouts do not use up the checksum. The checksum bytes are generated elsewhere and arrive here as a flat input vector.

Top module: `ckr_readout_ctrl`

## Requirements
- R1: After reset, `rd_sel_car` is 0, `addr` is 0 and `car_byte_idx` is 0, and the checksum is not armed.
- R2: The checksum is armed only by a command start with `cmd_is_read`=0 while `auth_valid` is 1. A read at address 0x20 with no such write since authentication keeps `rd_sel_car` at 0.
- R3: A read that starts at 0x20 while armed raises `rd_sel_car` from the cycle after the start. `car_byte_idx` counts 0 to 7, one step per `byte_strobe`, and `car_data` presents byte k of `car_bytes`, taken from bits [8k+7:8k].
- R4: `addr` loads `start_addr` on `cmd_start` and increments by one on each `byte_strobe`. This applies to both normal and checksum reads.
- R5: The eighth byte strobe of a checksum read drops `rd_sel_car`, and `addr` then reads 0x28. Further strobes continue as a normal read from there.
- R6: `cmd_end` during a checksum read closes it after any number of bytes, including zero. In limited mode, a later read at 0x20 within the same authentication is not selected.
- R7: A read command that starts at an address other than 0x20 disarms the checksum.
- R8: In limited mode (`cfg_unlim_n`=1), the checksum arms at most once per authentication. A one-cycle `auth_new` pulse clears that record, and a write in the same cycle as the pulse or later arms it again.
- R9: With `cfg_unlim_n`=0, a checksum read does not disarm the checksum, and any write under valid authentication re-arms it.
- R10: `rd_sel_car` is 0 in any cycle in which `auth_valid` is 0. Losing authentication disarms the checksum and ends any checksum read by the next clock edge.
- R11: When `cmd_start` coincides with `byte_strobe` or `cmd_end`, the new command wins: `addr` takes `start_addr` and is not incremented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auth_valid | input | 1 | Authentication currently in effect |
| auth_new | input | 1 | One-cycle pulse marking a fresh authentication |
| cfg_unlim_n | input | 1 | Active-low unlimited-readout configuration |
| cmd_start | input | 1 | First cycle of a command |
| cmd_is_read | input | 1 | Command type qualifier at `cmd_start` (1 = read) |
| start_addr | input | 8 | Start address of the command |
| byte_strobe | input | 1 | One data byte transferred |
| cmd_end | input | 1 | Command finished |
| car_bytes | input | 64 | Checksum bytes, byte 0 in the low bits |
| rd_sel_car | output | 1 | Read multiplexer selects checksum data |
| car_byte_idx | output | 3 | Index of the checksum byte now presented |
| addr | output | 8 | Internal address counter |
| car_data | output | 8 | Checksum byte now presented |

## Verification
The end of a checksum readout can be reached in two ways: by the eighth byte strobe and by `cmd_end`. The bench asserts both in the same cycle. It then judges that `rd_sel_car` falls once, that `addr` still advances to 0x28, and that a later read at 0x20 stays unselected. A second collision puts an `auth_new` pulse in the same cycle as a write command, and the checksum must come out armed. A behavioural model in the bench predicts the select, the index, the data and the address on every clock. Directed checks at these collisions compare against values derived from the requirements.

// File: rtl/ckr_pkg.sv
`timescale 1ns/1ps
package ckr_pkg;
   typedef struct packed {
      logic wr_start;
      logic rd_start;
      logic car_hit;
   } ckr_evt_t;
endpackage

// File: rtl/ckr_addr_ctr.sv
`timescale 1ns/1ps
module ckr_addr_ctr #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_start,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              byte_strobe,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           addr_q <= '0;
      else if (cmd_start)   addr_q <= start_addr;
      else if (byte_strobe) addr_q <= addr_q + 1'b1;
   end

   assign addr = addr_q;

   a_r4_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_strobe && !cmd_start) |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));
   a_r11_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_start |=> addr_q == $past(start_addr));
endmodule

// File: rtl/ckr_arm_ctrl.sv
`timescale 1ns/1ps
module ckr_arm_ctrl
   import ckr_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     auth_valid,
   input  logic     auth_new,
   input  logic     unlim,
   input  ckr_evt_t evt,
   output logic     armed
);
   logic armed_q, armed_d;
   logic used_q, used_d;

   always_comb begin
      armed_d = armed_q;
      used_d  = used_q;
      if (auth_new) begin
         armed_d = 1'b0;
         used_d  = 1'b0;
      end
      if (evt.rd_start && !(evt.car_hit && unlim))
         armed_d = 1'b0;
      if (evt.wr_start && auth_valid && (!used_d || unlim)) begin
         armed_d = 1'b1;
         used_d  = 1'b1;
      end
      if (!auth_valid)
         armed_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         used_q  <= 1'b0;
      end else begin
         armed_q <= armed_d;
         used_q  <= used_d;
      end
   end

   assign armed = armed_q;

   a_r10_disarm_on_auth_loss: assert property (@(posedge clk) disable iff (!rst_n)
      !auth_valid |=> !armed_q);
   a_r2_arm_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(evt.wr_start && auth_valid));
   a_r7_other_read_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (evt.rd_start && !evt.car_hit) |=> !armed_q);
   a_r8_single_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (used_q && !auth_new && !unlim && !armed_q) |=> !armed_q);
endmodule

// File: rtl/ckr_car_rd.sv
`timescale 1ns/1ps
module ckr_car_rd #(
   parameter int CAR_BYTES = 8,
   localparam int IDX_W = $clog2(CAR_BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             auth_valid,
   input  logic             cmd_start,
   input  logic             car_hit,
   input  logic             byte_strobe,
   input  logic             cmd_end,
   output logic             car_rd,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CAR_BYTES - 1);

   logic             car_rd_q, car_rd_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic             last_byte;

   assign last_byte = car_rd_q && byte_strobe && (idx_q == LAST_IDX);

   always_comb begin
      car_rd_d = car_rd_q;
      if (!auth_valid)                 car_rd_d = 1'b0;
      else if (cmd_start)              car_rd_d = car_hit;
      else if (cmd_end || last_byte)   car_rd_d = 1'b0;

      idx_d = idx_q;
      if (cmd_start)                        idx_d = '0;
      else if (car_rd_q && byte_strobe)     idx_d = idx_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         car_rd_q <= 1'b0;
         idx_q    <= '0;
      end else begin
         car_rd_q <= car_rd_d;
         idx_q    <= idx_d;
      end
   end

   assign car_rd = car_rd_q;
   assign idx    = idx_q;

   a_r5_close_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      (car_rd_q && byte_strobe && !cmd_start && idx_q == LAST_IDX) |=> !car_rd_q);
   a_r6_close_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      (car_rd_q && cmd_end && !cmd_start) |=> !car_rd_q);
   a_r3_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (car_rd_q && byte_strobe && !cmd_start && auth_valid && idx_q != LAST_IDX)
      |=> (car_rd_q && idx_q == IDX_W'($past(idx_q) + 1'b1)));
   a_r3_open_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_start && car_hit && auth_valid) |=> (car_rd_q && idx_q == '0));
endmodule

// File: rtl/ckr_byte_mux.sv
`timescale 1ns/1ps
module ckr_byte_mux #(
   parameter int BYTE_W    = 8,
   parameter int CAR_BYTES = 8,
   localparam int IDX_W = $clog2(CAR_BYTES)
) (
   input  logic [CAR_BYTES*BYTE_W-1:0] car_bytes,
   input  logic [IDX_W-1:0]            idx,
   output logic [BYTE_W-1:0]           data
);
   logic [BYTE_W-1:0] lane [CAR_BYTES];

   for (genvar g = 0; g < CAR_BYTES; g++) begin : g_lane
      assign lane[g] = car_bytes[g*BYTE_W +: BYTE_W];
   end

   assign data = lane[idx];
endmodule

// File: rtl/ckr_readout_ctrl.sv
`timescale 1ns/1ps
module ckr_readout_ctrl
   import ckr_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BYTE_W    = 8,
   parameter int CAR_BYTES = 8,
   parameter int CAR_ADDR  = 'h20,
   localparam int IDX_W   = $clog2(CAR_BYTES),
   localparam int VEC_W   = CAR_BYTES * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              auth_valid,
   input  logic              auth_new,
   input  logic              cfg_unlim_n,
   input  logic              cmd_start,
   input  logic              cmd_is_read,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic              byte_strobe,
   input  logic              cmd_end,
   input  logic [VEC_W-1:0]  car_bytes,
   output logic              rd_sel_car,
   output logic [IDX_W-1:0]  car_byte_idx,
   output logic [ADDR_W-1:0] addr,
   output logic [BYTE_W-1:0] car_data
);
   if (CAR_BYTES < 2 || (1 << IDX_W) != CAR_BYTES) begin : g_bad_bytes
      $error("CAR_BYTES must be a power of two of at least 2");
   end
   if (CAR_ADDR + CAR_BYTES > (1 << ADDR_W)) begin : g_bad_window
      $error("checksum window must fit in the address space");
   end

   localparam logic [ADDR_W-1:0] CAR_ADDR_V = ADDR_W'(CAR_ADDR);

   ckr_evt_t evt;
   logic     armed;
   logic     car_rd;

   always_comb begin
      evt.wr_start = cmd_start && !cmd_is_read;
      evt.rd_start = cmd_start && cmd_is_read;
      evt.car_hit  = evt.rd_start && armed && auth_valid && !auth_new
                     && (start_addr == CAR_ADDR_V);
   end

   ckr_arm_ctrl u_arm (
      .clk        (clk),
      .rst_n      (rst_n),
      .auth_valid (auth_valid),
      .auth_new   (auth_new),
      .unlim      (!cfg_unlim_n),
      .evt        (evt),
      .armed      (armed)
   );

   ckr_car_rd #(.CAR_BYTES(CAR_BYTES)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .auth_valid  (auth_valid),
      .cmd_start   (cmd_start),
      .car_hit     (evt.car_hit),
      .byte_strobe (byte_strobe),
      .cmd_end     (cmd_end),
      .car_rd      (car_rd),
      .idx         (car_byte_idx)
   );

   ckr_addr_ctr #(.ADDR_W(ADDR_W)) u_addr (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_start   (cmd_start),
      .start_addr  (start_addr),
      .byte_strobe (byte_strobe),
      .addr        (addr)
   );

   ckr_byte_mux #(.BYTE_W(BYTE_W), .CAR_BYTES(CAR_BYTES)) u_mux (
      .car_bytes (car_bytes),
      .idx       (car_byte_idx),
      .data      (car_data)
   );

   assign rd_sel_car = car_rd && auth_valid;

   a_r10_sel_needs_auth: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sel_car |-> auth_valid);
   a_r3_sel_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      rd_sel_car |-> (addr == CAR_ADDR_V + ADDR_W'(car_byte_idx)));
endmodule

// File: tb/ckr_readout_ctrl_tb_top.sv
`timescale 1ns/1ps
module ckr_readout_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        auth_valid = 1'b0, auth_new = 1'b0, cfg_unlim_n = 1'b1;
   logic        cmd_start = 1'b0, cmd_is_read = 1'b0, byte_strobe = 1'b0, cmd_end = 1'b0;
   logic [7:0]  start_addr = 8'h00;
   logic [63:0] car_bytes = 64'hF7E6_D5C4_B3A2_9180;
   logic        rd_sel_car;
   logic [2:0]  car_byte_idx;
   logic [7:0]  addr, car_data;

   int n_chk = 0, n_err = 0;
   bit done = 0;

   always #10 clk = ~clk;

   ckr_readout_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .auth_valid(auth_valid), .auth_new(auth_new),
      .cfg_unlim_n(cfg_unlim_n), .cmd_start(cmd_start), .cmd_is_read(cmd_is_read),
      .start_addr(start_addr), .byte_strobe(byte_strobe), .cmd_end(cmd_end),
      .car_bytes(car_bytes), .rd_sel_car(rd_sel_car), .car_byte_idx(car_byte_idx),
      .addr(addr), .car_data(car_data)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   bit m_ok, m_spent, m_rd;
   int m_cnt, m_addr;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ok = 0; m_spent = 0; m_rd = 0; m_cnt = 0; m_addr = 0;
      end else begin
         if (auth_new) begin m_spent = 0; m_ok = 0; end
         if (cmd_start) begin
            m_addr = start_addr;
            m_cnt = 0;
            if (cmd_is_read) begin
               m_rd = m_ok && auth_valid && (start_addr == 8'h20);
               if (!m_rd || cfg_unlim_n) m_ok = 0;
            end else begin
               m_rd = 0;
               if (auth_valid && (!m_spent || !cfg_unlim_n)) begin m_ok = 1; m_spent = 1; end
            end
         end else begin
            if (byte_strobe) begin
               m_addr = (m_addr + 1) % 256;
               if (m_rd) begin
                  m_cnt++;
                  if (m_cnt == 8) m_rd = 0;
               end
            end
            if (cmd_end) m_rd = 0;
         end
         if (!auth_valid) begin m_ok = 0; m_rd = 0; end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R3 model select", rd_sel_car, m_rd && auth_valid);
         check("R4 model addr", addr, m_addr);
         if (m_rd && auth_valid) begin
            check("R3 model index", car_byte_idx, m_cnt);
            check("R3 model data", car_data, (car_bytes >> (8*m_cnt)) & 64'hFF);
         end
      end
   end

   task automatic tick(); @(posedge clk); #2; endtask
   task automatic pulse_auth(); auth_new = 1; tick(); auth_new = 0; endtask
   task automatic wr_cmd();
      cmd_start = 1; cmd_is_read = 0; start_addr = 8'h40; tick();
      cmd_start = 0; cmd_end = 1; tick(); cmd_end = 0;
   endtask
   task automatic rd_open(input logic [7:0] a);
      cmd_start = 1; cmd_is_read = 1; start_addr = a; tick();
      cmd_start = 0; cmd_is_read = 0;
   endtask
   task automatic strobe(); byte_strobe = 1; tick(); byte_strobe = 0; endtask
   task automatic rd_close(); cmd_end = 1; tick(); cmd_end = 0; endtask

   initial begin
      repeat (3) tick();
      check("R1 reset select", rd_sel_car, 0);
      check("R1 reset addr", addr, 0);
      check("R1 reset index", car_byte_idx, 0);
      rst_n = 1; tick();
      check("R1 after release select", rd_sel_car, 0);

      // R2: write without authentication does not arm
      wr_cmd();
      auth_valid = 1; pulse_auth();
      rd_open(8'h20);
      check("R2 no write, no select", rd_sel_car, 0);
      check("R4 load addr", addr, 8'h20);
      rd_close();

      // R3, R5: full checksum readout then fall-through
      wr_cmd();
      rd_open(8'h20);
      check("R3 select on open", rd_sel_car, 1);
      for (int k = 0; k < 8; k++) begin
         check("R3 byte data", car_data, (car_bytes >> (8*k)) & 64'hFF);
         check("R3 byte index", car_byte_idx, k);
         strobe();
      end
      check("R5 select off after 8", rd_sel_car, 0);
      check("R5 addr after 8", addr, 8'h28);
      strobe(); strobe();
      check("R5 normal continuation", addr, 8'h2A);
      rd_close();

      // R8: second write in same authentication does not re-arm
      wr_cmd();
      rd_open(8'h20);
      check("R8 no second readout", rd_sel_car, 0);
      rd_close();

      // R8 + R6: auth_new together with a write, then early abort
      auth_new = 1; cmd_start = 1; cmd_is_read = 0; start_addr = 8'h50; tick();
      auth_new = 0; cmd_start = 0; rd_close();
      rd_open(8'h20);
      check("R8 re-armed by same-cycle auth and write", rd_sel_car, 1);
      strobe(); strobe(); strobe();
      check("R6 index mid read", car_byte_idx, 3);
      rd_close();
      check("R6 closed by end", rd_sel_car, 0);
      rd_open(8'h20);
      check("R6 consumed after abort", rd_sel_car, 0);
      rd_close();

      // R6: zero-byte readout consumes
      pulse_auth(); wr_cmd();
      rd_open(8'h20); rd_close();
      rd_open(8'h20);
      check("R6 zero-byte readout consumes", rd_sel_car, 0);
      rd_close();

      // R7: other-address read disarms
      pulse_auth(); wr_cmd();
      rd_open(8'h10); strobe(); rd_close();
      rd_open(8'h20);
      check("R7 other read disarms", rd_sel_car, 0);
      rd_close();

      // R11: start wins over strobe
      cmd_start = 1; cmd_is_read = 1; start_addr = 8'h05; byte_strobe = 1; tick();
      cmd_start = 0; byte_strobe = 0;
      check("R11 start beats strobe", addr, 8'h05);
      rd_close();

      // last strobe coinciding with cmd_end
      pulse_auth(); wr_cmd();
      rd_open(8'h20);
      repeat (7) strobe();
      check("R3 last byte presented", car_data, 8'hF7);
      byte_strobe = 1; cmd_end = 1; tick(); byte_strobe = 0; cmd_end = 0;
      check("R5 coinciding end select", rd_sel_car, 0);
      check("R5 coinciding end addr", addr, 8'h28);
      rd_open(8'h20);
      check("R6 coinciding end consumes", rd_sel_car, 0);
      rd_close();

      // R10: loss of authentication
      pulse_auth(); wr_cmd();
      rd_open(8'h20); strobe(); strobe();
      auth_valid = 0; #1;
      check("R10 select drops at once", rd_sel_car, 0);
      tick(); auth_valid = 1; #1;
      check("R10 read ended", rd_sel_car, 0);
      tick(); rd_close();
      rd_open(8'h20);
      check("R10 disarmed", rd_sel_car, 0);
      rd_close();

      // R9: unlimited readouts
      cfg_unlim_n = 0; pulse_auth(); wr_cmd();
      rd_open(8'h20); repeat (8) strobe(); rd_close();
      rd_open(8'h20);
      check("R9 repeat readout", rd_sel_car, 1);
      rd_close();
      rd_open(8'h10); rd_close();
      wr_cmd();
      rd_open(8'h20);
      check("R9 re-arm without new auth", rd_sel_car, 1);
      rd_close();
      cfg_unlim_n = 1;
      tick();

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_err++;
         $display("FAIL watchdog expired R1 actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule